// File: doc/BRIEF.md
# Two-Cache Snoop Bus Interconnect

This block joins two cache controllers through one shared coherence bus. It has two parts. An arbiter hands bus ownership to one cache at a time. A router takes every token a cache puts on the bus and delivers it to the other cache. Commands (read, read-exclusive, make-exclusive) pass to the peer's snoop input unchanged. Replies to a snoop are rewritten into what the requester has to see. When the peer cache supplies the line, or when it has no copy and main memory supplies it, the requester gets a data token. When the peer has acknowledged an invalidation, the requester gets a plain done.

Each cache has three interfaces:
- a claim/grant/release trio for bus ownership;
- an outgoing token channel with valid/ready;
- an incoming token channel with valid/ready.

Each token channel is buffered inside the block by a small FIFO, `QDEPTH` entries deep (default two). A cache that claims keeps `claim_req` high until it sees its grant. It owns the bus until it pulses `release_req`.

Top module: `snoop_xbar2`

## Requirements
- R1: At most one bit of `grant_own` is high at any time. A claim sampled while nobody owns the bus sets that cache's grant bit at the next clock edge.
- R2: A grant stays high until its owner's `release_req` is sampled, and it drops at that edge. While the bus is owned, the other cache's claim and release are ignored. A still-held claim is granted one edge after the bus goes idle.
- R3: When both caches claim while the bus is idle, the cache that was not granted last wins. After reset, cache 0 wins the first tie.
- R4: Command tokens RD=1, MX=2 and RX=3 from one cache reach the other cache's incoming channel unchanged.
- R5: A cache-supplies-data reply (code 4) from one cache is delivered to the other cache as a bus-to-cache data token (code 7).
- R6: A plain done reply (code 5) is delivered to the other cache as a data token (code 7), meaning memory supplies the line.
- R7: A make-exclusive-done reply (code 6) is delivered to the other cache as plain done (code 5).
- R8: Codes 0 and 7 sent by a cache are discarded. They are consumed and nothing is delivered to the peer.
- R9: Each channel holds `QDEPTH` tokens in order, and `up_ready` is low while its queue is full. An undelivered incoming token keeps its value until it is accepted.
- R10: A token accepted at edge k is valid at the peer after edge k+1, provided the peer's incoming queue had room at that edge.
- R11: After reset no grant is high, every queue is empty, both `up_ready` bits are high and both `dn_valid` bits are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| claim_req | input | 2 | Per-cache bus claim, held until granted |
| release_req | input | 2 | Per-cache release pulse from the owner |
| grant_own | output | 2 | Per-cache ownership, registered |
| up_valid | input | 2 | Per-cache outgoing token valid |
| up_tok | input | 2*TOK_W | Outgoing tokens, cache i in bits [i*TOK_W +: TOK_W] |
| up_ready | output | 2 | Outgoing queue has room |
| dn_valid | output | 2 | Incoming token available for cache i |
| dn_tok | output | 2*TOK_W | Incoming tokens, cache i in bits [i*TOK_W +: TOK_W] |
| dn_ready | input | 2 | Cache i accepts its incoming token |

## Verification
The arbiter's results are due one edge after the input that causes them. A grant appears one edge after an idle-bus claim, and it drops one edge after the owner's release. A routed token is due two edges after it is accepted: one edge into the outgoing queue, one edge across to the peer's incoming queue.

The bench drives inputs on the falling edge and reads outputs on the next falling edge. A behavioural queue model advances on every rising edge, so each comparison lands after exactly the edges counted above. Directed checks sample at those same falling edges, including one edge early to confirm that nothing arrives ahead of time.

// File: rtl/snx_pkg.sv
package snx_pkg;
  localparam int TOK_W = 3;

  typedef enum logic [TOK_W-1:0] {
    TK_NONE   = 3'd0,
    TK_RD     = 3'd1,
    TK_MX     = 3'd2,
    TK_RX     = 3'd3,
    TK_SUPPLY = 3'd4,
    TK_DONE   = 3'd5,
    TK_MXDONE = 3'd6,
    TK_DATA   = 3'd7
  } tok_t;

  typedef struct packed {
    logic keep;
    tok_t tok;
  } xlate_t;

  // Rewrite a token leaving one cache into what the peer must receive.
  function automatic xlate_t xlate(input logic [TOK_W-1:0] raw);
    xlate_t r;
    r.keep = 1'b1;
    r.tok  = TK_NONE;
    case (raw)
      TK_RD:     r.tok = TK_RD;
      TK_MX:     r.tok = TK_MX;
      TK_RX:     r.tok = TK_RX;
      TK_SUPPLY: r.tok = TK_DATA;
      TK_DONE:   r.tok = TK_DATA;
      TK_MXDONE: r.tok = TK_DONE;
      default:   r.keep = 1'b0;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/snx_fifo.sv
module snx_fifo #(
  parameter int W     = 3,
  parameter int DEPTH = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] wdata,
  input  logic         pop,
  output logic [W-1:0] rdata,
  output logic         full,
  output logic         empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
  localparam logic [CW-1:0] CMAX = CW'(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic [CW-1:0] cnt;
  logic          do_push, do_pop;

  assign full    = (cnt == CMAX);
  assign empty   = (cnt == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign rdata   = mem[rptr];

  always_ff @(posedge clk) begin
    if (do_push) mem[wptr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr <= '0;
      rptr <= '0;
      cnt  <= '0;
    end else begin
      if (do_push) wptr <= (wptr == LAST) ? '0 : wptr + 1'b1;
      if (do_pop)  rptr <= (rptr == LAST) ? '0 : rptr + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end
endmodule

// File: rtl/snx_arb.sv
module snx_arb (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] claim,
  input  logic [1:0] release_in,
  output logic [1:0] owner
);
  logic [1:0] own_q;
  logic       last_q;   // index of the cache granted most recently

  assign owner = own_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      own_q  <= 2'b00;
      last_q <= 1'b1;
    end else if (own_q == 2'b00) begin
      if (claim == 2'b11) begin
        own_q  <= last_q ? 2'b01 : 2'b10;
        last_q <= ~last_q;
      end else if (claim[0]) begin
        own_q  <= 2'b01;
        last_q <= 1'b0;
      end else if (claim[1]) begin
        own_q  <= 2'b10;
        last_q <= 1'b1;
      end
    end else if (|(own_q & release_in)) begin
      own_q <= 2'b00;
    end
  end
endmodule

// File: rtl/snx_route.sv
module snx_route
  import snx_pkg::*;
(
  input  logic [1:0]         up_empty,
  input  logic [2*TOK_W-1:0] up_data,
  input  logic [1:0]         dn_full,
  output logic [1:0]         up_pop,
  output logic [1:0]         dn_push,
  output logic [2*TOK_W-1:0] dn_data
);
  for (genvar d = 0; d < 2; d++) begin : g_dir
    localparam int P = 1 - d;
    xlate_t m;
    assign m       = xlate(up_data[d*TOK_W +: TOK_W]);
    assign up_pop[d]  = !up_empty[d] && !dn_full[P];
    assign dn_push[P] = up_pop[d] && m.keep;
    assign dn_data[P*TOK_W +: TOK_W] = m.tok;
  end
endmodule

// File: rtl/snoop_xbar2.sv
module snoop_xbar2
  import snx_pkg::*;
#(
  parameter int QDEPTH = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [1:0]         claim_req,
  input  logic [1:0]         release_req,
  output logic [1:0]         grant_own,
  input  logic [1:0]         up_valid,
  input  logic [2*TOK_W-1:0] up_tok,
  output logic [1:0]         up_ready,
  output logic [1:0]         dn_valid,
  output logic [2*TOK_W-1:0] dn_tok,
  input  logic [1:0]         dn_ready
);
  logic [1:0]         up_full, up_empty, up_pop;
  logic [1:0]         dn_full, dn_empty, dn_push;
  logic [2*TOK_W-1:0] up_head, dn_in;

  snx_arb u_arb (
    .clk        (clk),
    .rst        (rst),
    .claim      (claim_req),
    .release_in (release_req),
    .owner      (grant_own)
  );

  for (genvar i = 0; i < 2; i++) begin : g_cache
    snx_fifo #(.W(TOK_W), .DEPTH(QDEPTH)) u_upq (
      .clk   (clk),
      .rst   (rst),
      .push  (up_valid[i]),
      .wdata (up_tok[i*TOK_W +: TOK_W]),
      .pop   (up_pop[i]),
      .rdata (up_head[i*TOK_W +: TOK_W]),
      .full  (up_full[i]),
      .empty (up_empty[i])
    );

    snx_fifo #(.W(TOK_W), .DEPTH(QDEPTH)) u_dnq (
      .clk   (clk),
      .rst   (rst),
      .push  (dn_push[i]),
      .wdata (dn_in[i*TOK_W +: TOK_W]),
      .pop   (dn_ready[i]),
      .rdata (dn_tok[i*TOK_W +: TOK_W]),
      .full  (dn_full[i]),
      .empty (dn_empty[i])
    );

    assign up_ready[i] = !up_full[i];
    assign dn_valid[i] = !dn_empty[i];
  end

  snx_route u_route (
    .up_empty (up_empty),
    .up_data  (up_head),
    .dn_full  (dn_full),
    .up_pop   (up_pop),
    .dn_push  (dn_push),
    .dn_data  (dn_in)
  );
endmodule

// File: rtl/snoop_xbar2_chk.sv
module snoop_xbar2_chk #(
  parameter int TW = 3
) (
  input logic          clk,
  input logic          rst,
  input logic [1:0]    claim_req,
  input logic [1:0]    release_req,
  input logic [1:0]    grant_own,
  input logic [1:0]    dn_valid,
  input logic [1:0]    dn_ready,
  input logic [2*TW-1:0] dn_tok
);
  // R1
  grant_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant_own));

  for (genvar i = 0; i < 2; i++) begin : g_c
    // R1
    grant_from_idle_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(grant_own[i]) |-> ($past(grant_own) == 2'b00) && $past(claim_req[i]));
    // R2
    grant_hold_chk: assert property (@(posedge clk) disable iff (rst)
      grant_own[i] && !release_req[i] |=> grant_own[i]);
    // R2
    grant_drop_chk: assert property (@(posedge clk) disable iff (rst)
      grant_own[i] && release_req[i] |=> !grant_own[i]);
    // R9
    dn_stable_chk: assert property (@(posedge clk) disable iff (rst)
      dn_valid[i] && !dn_ready[i] |=> dn_valid[i] && $stable(dn_tok[i*TW +: TW]));
  end
endmodule

bind snoop_xbar2 snoop_xbar2_chk #(.TW(snx_pkg::TOK_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .claim_req   (claim_req),
  .release_req (release_req),
  .grant_own   (grant_own),
  .dn_valid    (dn_valid),
  .dn_ready    (dn_ready),
  .dn_tok      (dn_tok)
);

// File: tb/sim_snoop_xbar2.sv
`timescale 1ns/1ps
module sim_snoop_xbar2;
  localparam int TW = 3;
  localparam int QD = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic [1:0]      claim_req = '0, release_req = '0, up_valid = '0, dn_ready = 2'b11;
  logic [2*TW-1:0] up_tok = '0;
  wire  [1:0]      grant_own, up_ready, dn_valid;
  wire  [2*TW-1:0] dn_tok;

  snoop_xbar2 #(.QDEPTH(QD)) u0 (
    .clk(clk), .rst(rst), .claim_req(claim_req), .release_req(release_req),
    .grant_own(grant_own), .up_valid(up_valid), .up_tok(up_tok),
    .up_ready(up_ready), .dn_valid(dn_valid), .dn_tok(dn_tok), .dn_ready(dn_ready)
  );

  int total = 0, bad = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  // Expected peer token per requirement; -1 means discarded (R8).
  function automatic int peer_tok(input int t);
    case (t)
      1, 2, 3: return t;   // R4
      4:       return 7;   // R5
      5:       return 7;   // R6
      6:       return 5;   // R7
      default: return -1;  // R8
    endcase
  endfunction

  // Behavioural reference model
  int uq[2][$];
  int dq[2][$];
  int owner = -1;
  int last  = 1;

  always @(posedge clk) begin
    bit mv[2];
    int usz[2], dsz[2];
    if (rst) begin
      for (int i = 0; i < 2; i++) begin uq[i].delete(); dq[i].delete(); end
      owner = -1;
      last  = 1;
    end else begin
      for (int i = 0; i < 2; i++) begin usz[i] = uq[i].size(); dsz[i] = dq[i].size(); end
      for (int d = 0; d < 2; d++) mv[d] = (usz[d] > 0) && (dsz[1-d] < QD);
      for (int i = 0; i < 2; i++)
        if (dn_ready[i] && dsz[i] > 0) void'(dq[i].pop_front());
      for (int d = 0; d < 2; d++)
        if (mv[d]) begin
          int t;
          t = peer_tok(uq[d].pop_front());
          if (t >= 0) dq[1-d].push_back(t);
        end
      for (int i = 0; i < 2; i++)
        if (up_valid[i] && usz[i] < QD) uq[i].push_back(int'(up_tok[i*TW +: TW]));
      if (owner < 0) begin
        if (claim_req == 2'b11) begin owner = 1 - last; last = owner; end
        else if (claim_req[0]) begin owner = 0; last = 0; end
        else if (claim_req[1]) begin owner = 1; last = 1; end
      end else if (release_req[owner]) begin
        owner = -1;
      end
    end
  end

  // Per-cycle comparison against the model, away from the active edge
  always @(negedge clk) begin
    if (!rst) begin
      int eg;
      eg = (owner == 0) ? 1 : (owner == 1) ? 2 : 0;
      chk(grant_own == 2'(eg), "R3 grant vs model", int'(grant_own), eg);
      for (int i = 0; i < 2; i++) begin
        chk(up_ready[i] == (uq[i].size() < QD), "R9 up_ready vs model",
            int'(up_ready[i]), int'(uq[i].size() < QD));
        chk(dn_valid[i] == (dq[i].size() > 0), "R10 dn_valid vs model",
            int'(dn_valid[i]), int'(dq[i].size() > 0));
        if (dq[i].size() > 0)
          chk(int'(dn_tok[i*TW +: TW]) == dq[i][0], "R4 dn_tok vs model",
              int'(dn_tok[i*TW +: TW]), dq[i][0]);
      end
    end
  end

  task automatic send(input int c, input int t);
    @(negedge clk);
    up_valid[c] = 1'b1;
    up_tok[c*TW +: TW] = TW'(t);
    @(negedge clk);
    up_valid[c] = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL R1 watchdog expired act=0 exp=1");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    // R11 reset state
    chk(grant_own == 2'b00, "R11 grant after reset", int'(grant_own), 0);
    chk(up_ready == 2'b11, "R11 up_ready after reset", int'(up_ready), 3);
    chk(dn_valid == 2'b00, "R11 dn_valid after reset", int'(dn_valid), 0);

    // R1 grant one edge after idle claim
    claim_req[0] = 1'b1;
    @(negedge clk);
    chk(grant_own == 2'b01, "R1 grant after claim", int'(grant_own), 1);
    claim_req[0] = 1'b0;
    claim_req[1] = 1'b1;
    release_req[1] = 1'b1;
    @(negedge clk);
    release_req[1] = 1'b0;
    @(negedge clk);
    // R2 other claim and non-owner release ignored
    chk(grant_own == 2'b01, "R2 busy ignores peer", int'(grant_own), 1);
    release_req[0] = 1'b1;
    @(negedge clk);
    release_req[0] = 1'b0;
    chk(grant_own == 2'b00, "R2 drop after release", int'(grant_own), 0);
    @(negedge clk);
    chk(grant_own == 2'b10, "R2 pending claim granted", int'(grant_own), 2);
    claim_req[1] = 1'b0;
    release_req[1] = 1'b1;
    @(negedge clk);
    release_req[1] = 1'b0;

    // R3 ties alternate
    claim_req = 2'b11;
    @(negedge clk);
    chk(grant_own == 2'b01, "R3 tie after cache1", int'(grant_own), 1);
    release_req[0] = 1'b1;
    @(negedge clk);
    release_req[0] = 1'b0;
    @(negedge clk);
    chk(grant_own == 2'b10, "R3 tie after cache0", int'(grant_own), 2);
    claim_req = 2'b00;
    release_req[1] = 1'b1;
    @(negedge clk);
    release_req[1] = 1'b0;

    // R4..R8 token rewriting, with R10 timing
    for (int c = 0; c < 2; c++) begin
      for (int t = 0; t < 8; t++) begin
        int e;
        e = peer_tok(t);
        @(negedge clk);
        up_valid[c] = 1'b1;
        up_tok[c*TW +: TW] = TW'(t);
        @(negedge clk);
        up_valid[c] = 1'b0;
        chk(dn_valid[1-c] == 1'b0, "R10 not early", int'(dn_valid[1-c]), 0);
        @(negedge clk);
        if (e < 0) begin
          chk(dn_valid[1-c] == 1'b0, "R8 discarded", int'(dn_valid[1-c]), 0);
        end else begin
          chk(dn_valid[1-c] == 1'b1, "R10 arrives", int'(dn_valid[1-c]), 1);
          chk(int'(dn_tok[(1-c)*TW +: TW]) == e, (t == 4) ? "R5 supply" :
              (t == 5) ? "R6 done to data" : (t == 6) ? "R7 mxdone" : "R4 command",
              int'(dn_tok[(1-c)*TW +: TW]), e);
        end
      end
    end

    // R9 back-pressure and ordering
    dn_ready[1] = 1'b0;
    send(0, 1); send(0, 2); send(0, 3); send(0, 1);
    @(negedge clk);
    @(negedge clk);
    chk(up_ready[0] == 1'b0, "R9 up full", int'(up_ready[0]), 0);
    chk(int'(dn_tok[TW +: TW]) == 1, "R9 head held", int'(dn_tok[TW +: TW]), 1);
    dn_ready[1] = 1'b1;
    foreach (uq[0][k]) begin end
    begin
      int seq[4] = '{1, 2, 3, 1};
      for (int k = 0; k < 4; k++) begin
        chk(dn_valid[1] && int'(dn_tok[TW +: TW]) == seq[k], "R9 order",
            int'(dn_tok[TW +: TW]), seq[k]);
        @(negedge clk);
      end
    end

    // Random traffic, compared to the model every cycle
    for (int n = 0; n < 4000; n++) begin
      @(negedge clk);
      claim_req   = 2'($urandom);
      release_req = ($urandom_range(0, 2) == 0) ? 2'($urandom) : 2'b00;
      up_valid    = 2'($urandom);
      up_tok      = (2*TW)'($urandom);
      dn_ready    = 2'($urandom);
    end
    @(negedge clk);
    claim_req = '0; release_req = '0; up_valid = '0; dn_ready = 2'b11;
    repeat (8) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule